// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

The encoder turns one pointer event into a five-byte packet and writes it, one byte per clock, into an external byte FIFO that a serial channel drains. An event carries a signed X step, a signed Y step and the state of three buttons. It arrives through a valid/ready handshake. The encoder raises ready only when it is idle and the FIFO reports room for a whole packet. A packet therefore never splits across a full FIFO, and a new event is never taken while the previous packet is still being written.

The header byte carries the buttons active-low. The two motion bytes are saturated to a symmetric 8-bit range. The Y step is negated before it is saturated, so that screen-down input becomes a positive count. Two zero bytes close the packet.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset, push_o is low and no byte is written. evt_ready_o is high whenever fifo_free_i is 5 or more.
- R2: Byte 1 is 0x87 with bit 2 cleared when left is pressed, bit 1 cleared when middle is pressed and bit 0 cleared when right is pressed.
- R3: Byte 2 is the X step saturated to the range -127..+127, in two's complement.
- R4: Byte 3 is the negated Y step, saturated to -127..+127 after the negation. A Y step of -512 gives 0x7F and a Y step of +511 gives 0x81.
- R5: Bytes 4 and 5 are always 0x00.
- R6: An accepted event (evt_valid_i and evt_ready_o high at a rising edge) produces exactly five pushes on the five clocks that follow, in the order header, X, Y, zero, zero.
- R7: evt_ready_o stays low while fifo_free_i is below 5, and no event is accepted then.
- R8: evt_ready_o is low on every cycle in which push_o is high. A new event is taken only after the fifth byte.
- R9: Packet contents are fixed at acceptance. Changes on dx_i, dy_i or the button inputs during the pushes have no effect on the bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event present |
| evt_ready_o | output | 1 | Encoder can accept an event |
| dx_i | input | 10 | Signed X step |
| dy_i | input | 10 | Signed Y step |
| btn_left_i | input | 1 | Left button pressed |
| btn_mid_i | input | 1 | Middle button pressed |
| btn_right_i | input | 1 | Right button pressed |
| fifo_free_i | input | 9 | Free entries in the downstream FIFO |
| push_o | output | 1 | Write strobe to the FIFO |
| push_data_o | output | 8 | Byte being written |

## Verification
The hardest case to reach from the ports is an event that is ready and waiting when the FIFO has almost enough room. To reach it, the stimulus holds evt_valid_i high while fifo_free_i sits at 4 for several cycles, checks that nothing is taken, and then raises the free count. A second hard case is a change to the inputs in the middle of a packet: after each accept, the bench drives unrelated values on dx_i, dy_i and the buttons, while the scoreboard still expects the bytes captured at acceptance. Saturation is exercised at both extremes of the 10-bit input and just past ±127.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;
  localparam int PKT_LEN = 5;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] HDR_BASE = 8'h87;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PKT_LEN-1:0][BYTE_W-1:0] pkt_t;

  // buttons are active-low inside the header
  function automatic byte_t hdr_byte(input logic l, input logic m, input logic r);
    return HDR_BASE ^ {5'b0, l, m, r};
  endfunction
endpackage

// File: rtl/mpe_clamp.sv
module mpe_clamp #(
  parameter int IN_W = 10,
  parameter int OUT_W = 8,
  parameter bit NEGATE = 1'b0
) (
  input  logic signed [IN_W-1:0]  val_i,
  output logic        [OUT_W-1:0] val_o
);
  localparam int EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] LIM_HI = EXT_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] LIM_LO = -LIM_HI;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] sat;

  // extend before negation so the most negative input has a positive image
  generate
    if (NEGATE) begin : g_neg
      assign ext = -(EXT_W'(val_i));
    end else begin : g_pos
      assign ext = EXT_W'(val_i);
    end
  endgenerate

  always_comb begin
    if (ext > LIM_HI)      sat = LIM_HI;
    else if (ext < LIM_LO) sat = LIM_LO;
    else                   sat = ext;
  end

  assign val_o = sat[OUT_W-1:0];
endmodule

// File: rtl/mpe_sequencer.sv
module mpe_sequencer
  import mouse_pkt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  pkt_t  pkt_i,
  output logic  busy_o,
  output logic  push_o,
  output byte_t data_o
);
  localparam int IDX_W = $clog2(PKT_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  pkt_t             pkt_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      pkt_q  <= pkt_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign push_o = busy_q;
  assign data_o = pkt_q[idx_q];
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mouse_pkt_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int FREE_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  output logic               evt_ready_o,
  input  logic [DELTA_W-1:0] dx_i,
  input  logic [DELTA_W-1:0] dy_i,
  input  logic               btn_left_i,
  input  logic               btn_mid_i,
  input  logic               btn_right_i,
  input  logic [FREE_W-1:0]  fifo_free_i,
  output logic               push_o,
  output logic [7:0]         push_data_o
);
  localparam logic [FREE_W-1:0] NEED = FREE_W'(PKT_LEN);

  byte_t x_b, y_b;
  pkt_t  pkt;
  logic  busy;
  logic  accept;

  mpe_clamp #(.IN_W(DELTA_W), .OUT_W(BYTE_W), .NEGATE(1'b0)) u_clamp_x (
    .val_i(dx_i), .val_o(x_b)
  );
  mpe_clamp #(.IN_W(DELTA_W), .OUT_W(BYTE_W), .NEGATE(1'b1)) u_clamp_y (
    .val_i(dy_i), .val_o(y_b)
  );

  // byte 0 goes out first
  always_comb begin
    pkt    = '0;
    pkt[0] = hdr_byte(btn_left_i, btn_mid_i, btn_right_i);
    pkt[1] = x_b;
    pkt[2] = y_b;
  end

  assign evt_ready_o = !busy && (fifo_free_i >= NEED);
  assign accept      = evt_valid_i && evt_ready_o;

  mpe_sequencer u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .pkt_i  (pkt),
    .busy_o (busy),
    .push_o (push_o),
    .data_o (push_data_o)
  );
endmodule

// File: rtl/mouse_pkt_enc_chk.sv
module mouse_pkt_enc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_valid_i,
  input logic       evt_ready_o,
  input logic [8:0] fifo_free_i,
  input logic       push_o,
  input logic [7:0] push_data_o
);
  logic [3:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (push_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_ACCEPT_PUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_ready_o) |=> push_o); // R6
  AST_RUN_IS_FIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(push_o) |-> ($past(run_q) == 4'd4)); // R6
  AST_NO_READY_WHILE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !evt_ready_o); // R8
  AST_ROOM_FOR_PACKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_free_i < 9'd5) |-> !evt_ready_o); // R7
  AST_HDR_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && run_q == 4'd0) |-> (push_data_o[7:3] == 5'b10000)); // R2
  AST_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && run_q >= 4'd3) |-> (push_data_o == 8'h00)); // R5
endmodule

bind mouse_pkt_enc mouse_pkt_enc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_valid_i(evt_valid_i),
  .evt_ready_o(evt_ready_o),
  .fifo_free_i(fifo_free_i),
  .push_o     (push_o),
  .push_data_o(push_data_o)
);

// File: tb/mouse_pkt_enc_tb_top.sv
module mouse_pkt_enc_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_valid_i = 1'b0;
  logic       evt_ready_o;
  logic [9:0] dx_i = '0;
  logic [9:0] dy_i = '0;
  logic       btn_left_i = 1'b0;
  logic       btn_mid_i = 1'b0;
  logic       btn_right_i = 1'b0;
  logic [8:0] fifo_free_i = 9'd16;
  logic       push_o;
  logic [7:0] push_data_o;

  int checks = 0;
  int errors = 0;
  int run = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk_i = ~clk_i;

  mouse_pkt_enc dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sat(input int v);
    if (v > 127) v = 127;
    if (v < -127) v = -127;
    return 8'(v);
  endfunction

  // monitor: scoreboard pop and run-length tracking
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (push_o) begin
        check(!evt_ready_o, "R8", evt_ready_o, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected byte", push_data_o, 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(push_data_o == e, t, push_data_o, e);
        end
        run++;
      end else if (run != 0) begin
        check(run == 5, "R6 run length", run, 5);
        run = 0;
      end
    end
  end

  task automatic send(input int dx, input int dy, input bit l, input bit m, input bit r);
    @(negedge clk_i);
    dx_i = 10'(dx); dy_i = 10'(dy);
    btn_left_i = l; btn_mid_i = m; btn_right_i = r;
    evt_valid_i = 1'b1;
    while (!evt_ready_o) @(negedge clk_i);
    exp_q.push_back(8'h87 ^ {5'b0, l, m, r}); tag_q.push_back("R2 header");
    exp_q.push_back(sat(dx));                 tag_q.push_back("R3 x byte");
    exp_q.push_back(sat(-dy));                tag_q.push_back("R4 y byte");
    exp_q.push_back(8'h00);                   tag_q.push_back("R5 pad 1");
    exp_q.push_back(8'h00);                   tag_q.push_back("R5 pad 2");
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    // R9: scramble inputs while the packet is written
    dx_i = 10'h155; dy_i = 10'h2AA;
    btn_left_i = ~l; btn_mid_i = ~m; btn_right_i = ~r;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || push_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(push_o == 1'b0, "R1 push idle", push_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(push_o == 1'b0, "R1 push after reset", push_o, 0);
    check(evt_ready_o == 1'b1, "R1 ready after reset", evt_ready_o, 1);

    send(5, 3, 0, 0, 0);
    drain();
    send(-512, -512, 1, 1, 1);
    drain();
    send(127, -127, 1, 0, 0);
    drain();
    send(128, 128, 0, 1, 0);
    drain();
    send(-128, 0, 0, 0, 1);
    drain();
    send(-127, 511, 1, 0, 1);
    drain();

    // R7: event waiting, FIFO one short
    @(negedge clk_i);
    fifo_free_i = 9'd4;
    evt_valid_i = 1'b1;
    dx_i = 10'd9;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check(!evt_ready_o, "R7 ready with 4 free", evt_ready_o, 0);
      check(!push_o, "R7 no push with 4 free", push_o, 0);
    end
    evt_valid_i = 1'b0;
    fifo_free_i = 9'd5;
    @(negedge clk_i);
    check(evt_ready_o, "R7 ready with 5 free", evt_ready_o, 1);
    send(9, -1, 0, 1, 1);
    drain();

    // R8: back-to-back events, valid re-raised during the packet
    fifo_free_i = 9'd200;
    send(1, 1, 0, 0, 0);
    send(-2, -2, 1, 1, 0);
    drain();

    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule